// File: doc/BRIEF.md
# External Memory Expansion Bus Controller

This block sits between a CPU with a 16-bit address space and a multiplexed external memory bus. Each CPU request is decoded. An address inside the internal ROM region or the internal high region (RAM and special registers) completes in the same cycle and never touches the bus. Every other address is an external access. No special instruction or addressing mode is needed. The controller then runs a fixed bus sequence. First comes an address state, qualified by a one-cycle latch-enable pulse. An optional turnaround state follows, then a read slot and a write slot, each of which can be stretched by a wait state.

A mode register sets how many low address bits reach the pins: 12, 14 or 16. The external memory therefore repeats every 4 KB or every 16 KB, or it sees the full CPU address. The unused upper pins are held at zero. A read asserts only the read strobe and a write asserts only the write strobe, but both kinds of access pass through both slots. The wait and delayed-enable settings are register bits. All configuration is captured when an access starts, so a change made during a bus cycle only applies to the next access.

Top module: `xbus_expander`

## Requirements
- R1: An address below ROM_END (default 6000H) or at or above HI_BASE (default FF00H) is internal. `intSel` is high in the same cycle, `ready` stays high, and no latch-enable or strobe follows.
- R2: An external request accepted while `ready` is high drives `ready` low from the next cycle until the last state of the sequence has ended.
- R3: The first state of an external access drives `ale` high for exactly one cycle, with `busOe` high and the address on `busOut`.
- R4: Mode code 0 drives the low 12 address bits and code 1 the low 14 bits. Codes 2 and 3 drive all 16 bits. The upper bits are driven as zero. In mode 1, 6000H drives 2000H and 8000H drives 0000H.
- R5: A read pulls `rdN` low for the whole read slot and never pulls `wrN` low. `busOe` stays low after the address state. `rdata` takes `busDataIn` as sampled in the last read-slot cycle and holds it once `ready` returns.
- R6: A write pulls `wrN` low for the whole write slot and never pulls `rdN` low. From the read slot to the end of the access, `busOut` carries the zero-extended write data with `busOe` high.
- R7: With the wait bit set, each slot lasts two cycles instead of one. An access keeps `ready` low for 3 + delay + 2×wait cycles.
- R8: With the delay bit set, one cycle with `busOe` low and no strobes is inserted between the address state and the read slot.
- R9: Configuration writes made during an access do not change that access. They apply from the next access on.
- R10: After reset: `ready`=1, `rdN`=`wrN`=1, `ale`=0, `busOe`=0. The configuration resets to mode 0 with no wait and no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Write strobe for configuration register |
| cfgMode | input | 2 | Address-width mode code |
| cfgWait | input | 1 | Wait-state enable |
| cfgDelayOe | input | 1 | Delayed read-enable turnaround enable |
| reqValid | input | 1 | CPU access request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | CPU address |
| reqWdata | input | DATA_W | CPU write data |
| ready | output | 1 | Controller idle / access finished |
| intSel | output | 1 | Request hits internal memory this cycle |
| rdata | output | DATA_W | Read data from external bus |
| ale | output | 1 | Address latch enable pulse |
| rdN | output | 1 | Active-low read strobe |
| wrN | output | 1 | Active-low write strobe |
| busOut | output | ADDR_W | Multiplexed address/data out |
| busOe | output | 1 | Bus output enable |
| busDataIn | input | DATA_W | Data returned on the bus |

## Verification
The bench builds the block with its defaults: a 16-bit address, 8-bit data, 12- and 14-bit narrow windows, ROM_END of 6000H and HI_BASE of FF00H. With these values the bench reaches the aliasing cases (6000H to 2000H, 8000H to 0000H) and both edges of the internal decode (5FFFH/6000H and FEFFH/FF00H). The input data differs in every cycle except the one where a capture is expected, so a capture taken in the wrong cycle shows up.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_TURN, ST_RSLOT, ST_RWAIT, ST_WSLOT, ST_WWAIT
  } xbState_t;

  typedef enum logic [1:0] {
    MODE_4K = 2'd0, MODE_16K = 2'd1, MODE_64K = 2'd2, MODE_64K_ALT = 2'd3
  } xbMode_t;

  typedef struct packed {
    logic    load;
    logic    driveAddr;
    logic    driveData;
    logic    capture;
    xbMode_t mode;
  } xbStrobe_t;

endpackage

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int          ADDR_W  = 16,
  parameter int unsigned ROM_END = 'h6000,
  parameter int unsigned HI_BASE = 'hFF00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgMode,
  input  logic              cfgWait,
  input  logic              cfgDelayOe,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              ready,
  output logic              intSel,
  output logic              ale,
  output logic              rdN,
  output logic              wrN,
  output xbStrobe_t         strobe
);

  localparam logic [ADDR_W-1:0] RomEndA = ADDR_W'(ROM_END);
  localparam logic [ADDR_W-1:0] HiBaseA = ADDR_W'(HI_BASE);

  xbState_t state, nxtState;
  xbMode_t  cfgModeQ, curMode;
  logic     cfgWaitQ, cfgDlyQ, curWait, curDly, curWrite;
  logic     isInternal, idle, start, inRead, inWrite;

  assign isInternal = (reqAddr < RomEndA) || (reqAddr >= HiBaseA);
  assign idle       = (state == ST_IDLE);
  assign start      = idle && reqValid && !isInternal;
  assign ready      = idle;
  assign intSel     = idle && reqValid && isInternal;

  // configuration register, visible to the sequencer only at start
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgModeQ <= MODE_4K;
      cfgWaitQ <= 1'b0;
      cfgDlyQ  <= 1'b0;
    end else if (cfgWe) begin
      cfgModeQ <= xbMode_t'(cfgMode);
      cfgWaitQ <= cfgWait;
      cfgDlyQ  <= cfgDelayOe;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      curMode  <= MODE_4K;
      curWait  <= 1'b0;
      curDly   <= 1'b0;
      curWrite <= 1'b0;
    end else begin
      state <= nxtState;
      if (start) begin
        curMode  <= cfgModeQ;
        curWait  <= cfgWaitQ;
        curDly   <= cfgDlyQ;
        curWrite <= reqWrite;
      end
    end
  end

  always_comb begin
    nxtState = state;
    unique case (state)
      ST_IDLE:  if (start) nxtState = ST_ADDR;
      ST_ADDR:  nxtState = curDly ? ST_TURN : ST_RSLOT;
      ST_TURN:  nxtState = ST_RSLOT;
      ST_RSLOT: nxtState = curWait ? ST_RWAIT : ST_WSLOT;
      ST_RWAIT: nxtState = ST_WSLOT;
      ST_WSLOT: nxtState = curWait ? ST_WWAIT : ST_IDLE;
      ST_WWAIT: nxtState = ST_IDLE;
      default:  nxtState = ST_IDLE;
    endcase
  end

  assign inRead  = (state == ST_RSLOT) || (state == ST_RWAIT);
  assign inWrite = (state == ST_WSLOT) || (state == ST_WWAIT);
  assign ale     = (state == ST_ADDR);
  assign rdN     = !(inRead && !curWrite);
  assign wrN     = !(inWrite && curWrite);

  always_comb begin
    strobe.load      = start;
    strobe.driveAddr = (state == ST_ADDR);
    strobe.driveData = curWrite && (inRead || inWrite);
    strobe.capture   = !curWrite && (((state == ST_RSLOT) && !curWait) || (state == ST_RWAIT));
    strobe.mode      = curMode;
  end

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!idle && state != ST_ADDR) |-> ($stable(curMode) && $stable(curWait) && $stable(curDly))); // R9
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN)); // R5
  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && ready && !intSel) |=> !ready); // R2
  AST_INT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    intSel |=> (ready && !ale)); // R1
  AST_ALE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale); // R3

endmodule

// File: rtl/xbus_dp.sv
module xbus_dp
  import xbus_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int NARROW_W = 12,
  parameter int MID_W    = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  xbStrobe_t         strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [ADDR_W-1:0] busOut,
  output logic              busOe,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [ADDR_W-1:0] MaskNarrow = ADDR_W'((1 << NARROW_W) - 1);
  localparam logic [ADDR_W-1:0] MaskMid    = ADDR_W'((1 << MID_W) - 1);
  localparam logic [ADDR_W-1:0] MaskFull   = '1;

  logic [ADDR_W-1:0] addrQ, winMask;
  logic [DATA_W-1:0] dataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      rdata <= '0;
    end else begin
      if (strobe.load) begin
        addrQ <= reqAddr;
        dataQ <= reqWdata;
      end
      if (strobe.capture) rdata <= busDataIn;
    end
  end

  always_comb begin
    unique case (strobe.mode)
      MODE_4K:  winMask = MaskNarrow;
      MODE_16K: winMask = MaskMid;
      default:  winMask = MaskFull;
    endcase
  end

  always_comb begin
    if (strobe.driveAddr)      busOut = addrQ & winMask;
    else if (strobe.driveData) busOut = {{(ADDR_W-DATA_W){1'b0}}, dataQ};
    else                       busOut = '0;
  end

  assign busOe = strobe.driveAddr || strobe.driveData;

  AST_CAPTURE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |-> !busOe); // R5
  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(rdata)); // R5

endmodule

// File: rtl/xbus_expander.sv
module xbus_expander
  import xbus_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 8,
  parameter int          NARROW_W = 12,
  parameter int          MID_W    = 14,
  parameter int unsigned ROM_END  = 'h6000,
  parameter int unsigned HI_BASE  = 'hFF00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgMode,
  input  logic              cfgWait,
  input  logic              cfgDelayOe,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              ready,
  output logic              intSel,
  output logic [DATA_W-1:0] rdata,
  output logic              ale,
  output logic              rdN,
  output logic              wrN,
  output logic [ADDR_W-1:0] busOut,
  output logic              busOe,
  input  logic [DATA_W-1:0] busDataIn
);

  xbStrobe_t strobe;

  xbus_ctrl #(.ADDR_W(ADDR_W), .ROM_END(ROM_END), .HI_BASE(HI_BASE)) i_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgMode(cfgMode), .cfgWait(cfgWait),
    .cfgDelayOe(cfgDelayOe), .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .ready(ready), .intSel(intSel), .ale(ale), .rdN(rdN), .wrN(wrN), .strobe(strobe)
  );

  xbus_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NARROW_W(NARROW_W), .MID_W(MID_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .busDataIn(busDataIn), .busOut(busOut), .busOe(busOe), .rdata(rdata)
  );

  AST_NO_DRIVE_UNDER_RD: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !busOe); // R5
  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> busOe); // R6

endmodule

// File: tb/test_xbus_expander.sv
`timescale 1ns/1ps
module test_xbus_expander;

  typedef struct {
    logic        rdy, ale, rdN, wrN, oe;
    logic [15:0] bus;
    bit          cap;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0, cfgWait = 1'b0, cfgDelayOe = 1'b0;
  logic [1:0]  cfgMode = 2'd0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0, busDataIn = '0;
  logic        ready, intSel, ale, rdN, wrN, busOe;
  logic [7:0]  rdata;
  logic [15:0] busOut;

  int nChecks = 0, nFails = 0;
  bit done = 0;
  int mdlMode = 0;
  bit mdlWait = 0, mdlDly = 0;

  always #10 clk = ~clk;

  xbus_expander i_xbus_expander (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgMode(cfgMode), .cfgWait(cfgWait),
    .cfgDelayOe(cfgDelayOe), .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .ready(ready), .intSel(intSel), .rdata(rdata), .ale(ale),
    .rdN(rdN), .wrN(wrN), .busOut(busOut), .busOe(busOe), .busDataIn(busDataIn)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    nChecks++;
    if (act !== expv) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  function automatic logic [15:0] windowOf(input int m);
    if (m == 0) return 16'h0FFF;
    if (m == 1) return 16'h3FFF;
    return 16'hFFFF;
  endfunction

  task automatic writeCfg(input int m, input bit w, input bit dl);
    cfgWe = 1; cfgMode = 2'(m); cfgWait = w; cfgDelayOe = dl;
    @(negedge clk);
    cfgWe = 0;
    mdlMode = m; mdlWait = w; mdlDly = dl;
  endtask

  // R1: internal access, checked in its own cycle and the next
  task automatic intAccess(input logic [15:0] a);
    reqValid = 1; reqWrite = 0; reqAddr = a;
    #1;
    chk("R1 intSel", intSel, 1);
    chk("R1 ready", ready, 1);
    @(posedge clk); #1 reqValid = 0;
    @(negedge clk);
    chk("R1 ready after", ready, 1);
    chk("R1 no ale", ale, 0);
    chk("R1 no strobe", {rdN, wrN}, 2'b11);
  endtask

  task automatic extAccess(input bit wr, input logic [15:0] a, input logic [7:0] d,
                           input logic [7:0] inVal, input bit cfgMid, input int nMode,
                           input bit nWait, input bit nDly, input string cntTag);
    exp_t q[$];
    exp_t e;
    logic [15:0] mask;
    int lowCnt, n;
    mask = windowOf(mdlMode);
    n = 3 + int'(mdlDly) + 2 * int'(mdlWait);
    e = '{rdy:0, ale:1, rdN:1, wrN:1, oe:1, bus:a & mask, cap:0}; q.push_back(e);
    if (mdlDly) begin e = '{rdy:0, ale:0, rdN:1, wrN:1, oe:0, bus:0, cap:0}; q.push_back(e); end
    e = '{rdy:0, ale:0, rdN:wr, wrN:1, oe:wr, bus:{8'h00, d}, cap:(!wr && !mdlWait)}; q.push_back(e);
    if (mdlWait) begin e.cap = !wr; q.push_back(e); end
    e = '{rdy:0, ale:0, rdN:1, wrN:!wr, oe:wr, bus:{8'h00, d}, cap:0}; q.push_back(e);
    if (mdlWait) q.push_back(e);
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = d; busDataIn = ~inVal;
    @(posedge clk); #1 reqValid = 0;
    lowCnt = 0;
    for (int i = 0; i < q.size(); i++) begin
      @(negedge clk);
      e = q[i];
      chk("R2 ready", ready, e.rdy);
      chk("R3 ale", ale, e.ale);
      chk("R5 rdN", rdN, e.rdN);
      chk("R6 wrN", wrN, e.wrN);
      chk("R8 busOe", busOe, e.oe);
      if (e.oe) chk(e.ale ? "R4 address" : "R6 data", busOut, e.bus);
      if (!ready) lowCnt++;
      busDataIn = e.cap ? inVal : ~inVal;
      if (cfgMid && i == 0) begin
        cfgWe = 1; cfgMode = 2'(nMode); cfgWait = nWait; cfgDelayOe = nDly;
      end else cfgWe = 0;
    end
    if (cfgMid) begin mdlMode = nMode; mdlWait = nWait; mdlDly = nDly; end
    @(negedge clk);
    chk("R2 ready back", ready, 1);
    if (!wr) chk("R5 rdata", rdata, inVal);
    chk(cntTag, lowCnt, n);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    #1;
    chk("R10 ready in reset", ready, 1);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R10 ready", ready, 1);
    chk("R10 strobes", {rdN, wrN}, 2'b11);
    chk("R10 ale", ale, 0);
    chk("R10 busOe", busOe, 0);
    // R1 decode boundaries
    intAccess(16'h1234);
    intAccess(16'h5FFF);
    intAccess(16'hFF00);
    intAccess(16'hFFFF);
    // reset config: mode 0 (12 bits), R10 / R4
    extAccess(0, 16'h6000, 8'h00, 8'h5A, 0, 0, 0, 0, "R10 cycles");
    extAccess(1, 16'h7ABC, 8'hC3, 8'h00, 0, 0, 0, 0, "R2 cycles");
    // R4 mode 1 aliasing
    writeCfg(1, 0, 0);
    extAccess(0, 16'h6000, 8'h00, 8'hA5, 0, 0, 0, 0, "R2 cycles");
    extAccess(0, 16'h8000, 8'h00, 8'h3C, 0, 0, 0, 0, "R2 cycles");
    extAccess(1, 16'hB123, 8'h7E, 8'h00, 0, 0, 0, 0, "R2 cycles");
    extAccess(0, 16'hFEFF, 8'h00, 8'h11, 0, 0, 0, 0, "R2 cycles");
    // R4 full width, both codes
    writeCfg(2, 0, 0);
    extAccess(0, 16'hFEFF, 8'h00, 8'h96, 0, 0, 0, 0, "R2 cycles");
    writeCfg(3, 0, 0);
    extAccess(1, 16'h9001, 8'h42, 8'h00, 0, 0, 0, 0, "R2 cycles");
    // R7 wait states
    writeCfg(1, 1, 0);
    extAccess(0, 16'hC555, 8'h00, 8'hE7, 0, 0, 0, 0, "R7 cycles");
    extAccess(1, 16'hC556, 8'h18, 8'h00, 0, 0, 0, 0, "R7 cycles");
    // R8 delayed enable, alone and with wait
    writeCfg(0, 0, 1);
    extAccess(0, 16'h6FFF, 8'h00, 8'h81, 0, 0, 0, 0, "R8 cycles");
    extAccess(1, 16'h6FFE, 8'hF0, 8'h00, 0, 0, 0, 0, "R8 cycles");
    writeCfg(2, 1, 1);
    extAccess(0, 16'hABCD, 8'h00, 8'h2D, 0, 0, 0, 0, "R8 cycles");
    // R9 configuration changed mid-access
    writeCfg(1, 0, 0);
    extAccess(0, 16'h7000, 8'h00, 8'h66, 1, 0, 1, 1, "R9 cycles");
    extAccess(1, 16'h7123, 8'h99, 8'h00, 1, 2, 0, 0, "R9 cycles");
    extAccess(0, 16'h8765, 8'h00, 8'h4B, 0, 0, 0, 0, "R9 cycles");
    summary();
  end

endmodule